// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates the interrupt requests of a small microcontroller core among five sources: external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. It holds a per-source enable mask with a global enable, and a per-source level select that places each source at a low or a high priority level. When the core signals an instruction boundary, the block picks one winning request. It then issues a one-cycle take pulse together with the fixed entry address for that source.

The block records which levels are in service. A low-level handler can only be interrupted by a high-level request. A high-level handler cannot be interrupted at all. A return strobe from the core ends the most recent level, and the high level is always ended first. The timer overflow events are latched inside the block and cleared when their entry is taken. The external and serial requests are level inputs that their owners clear. Stacking the return address and redirecting the fetch are left to the core.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `take` and `vec_addr` are 0, all enable and level bits are 0, and no request is taken.
- R2: The entry address is 8*i + 3 for source index i, where index 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1 and 4 is serial. This gives 0x03, 0x0B, 0x13, 0x1B and 0x23.
- R3: While enable bit 5 (the global enable) is 0, no request is taken.
- R4: Enable bit i (for i from 0 to 4) masks source i. A disabled source is never taken.
- R5: A request is taken only at an instruction boundary. `take` is high for exactly the one cycle after a cycle with `insn_done` high and an eligible request.
- R6: Level bit i = 1 places source i at the high level. When both levels have eligible requests, the high-level one wins, regardless of the polling order.
- R7: Within one level, the lowest source index wins. The order is external 0, timer 0, external 1, timer 1, then serial.
- R8: While only the low level is in service, a high-level request is taken and a low-level request waits.
- R9: While the high level is in service, no request is taken.
- R10: Each take marks its level as in service. `reti` ends the high level if that level is in service, and otherwise ends the low level. Once both levels have ended, low requests can be taken again.
- R11: A timer overflow pulse is held until its entry is taken, and the take clears it. The serial request is the OR of the transmit and receive flags. The serial request and the external requests are not cleared by a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | Enable value: bits 4..0 enable each source, bit 5 is the global enable |
| pri_we | input | 1 | Write strobe for the level register |
| pri_wdata | input | 5 | Level value: bit i = 1 places source i at the high level |
| ext0_req | input | 1 | External request 0 (level) |
| ext1_req | input | 1 | External request 1 (level) |
| tmr0_ovf | input | 1 | Timer 0 overflow event (pulse) |
| tmr1_ovf | input | 1 | Timer 1 overflow event (pulse) |
| ser_tx_flag | input | 1 | Serial transmit-done flag |
| ser_rx_flag | input | 1 | Serial receive-done flag |
| insn_done | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-handler strobe |
| take | output | 1 | One-cycle take pulse |
| vec_addr | output | 16 | Entry address of the taken source, valid with `take` |

## Verification
Each source is first raised on its own to confirm its entry address. The sources are then raised in pairs. Pairs at the same level show that the polling order decides. Pairs at different levels show that the level select overrides that order. Holding a request across a take and a return tells the three cases apart: a level-held request comes back, a latched timer event does not come back, and a request inside a handler is either blocked or nests, depending on the levels in service. Applying requests while the global or individual enables are off, and between boundaries, confirms that those requests stay silent.

// File: rtl/vic_pkg.sv
// Package: shared constants, the arbitration result type and a helper that
// finds the lowest set bit. Assumes the five-source layout of the top module.
package vic_pkg;
    localparam int SRC_N = 5;
    localparam int IDX_W = $clog2(SRC_N);

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Lowest set index of a request vector (0 when empty).
    function automatic logic [IDX_W-1:0] lowest_idx(input logic [SRC_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/vic_flags.sv
// Request flag stage: the bits chosen by LATCH_MASK capture event pulses and
// hold them until cleared, while the other bits pass level requests through.
// Assumes clr is a one-hot clear from the take logic; a new event wins over a clear.
module vic_flags #(
    parameter int               N          = 5,
    parameter logic [N-1:0]     LATCH_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_src
        if (LATCH_MASK[i]) begin : g_latch
            logic held_q;
            // Hold the event until its entry is taken.
            always_ff @(posedge clk) begin
                if (!rst_n)       held_q <= 1'b0;
                else if (evt[i])  held_q <= 1'b1;
                else if (clr[i])  held_q <= 1'b0;
            end
            assign flag[i] = held_q;
        end else begin : g_level
            assign flag[i] = evt[i];
        end
    end
endmodule

// File: rtl/vic_pick.sv
// Arbiter: picks one eligible request from the pending vector, using the
// level-select bits and the in-service state. Purely combinational.
// Assumes pend is already masked by the enables.
module vic_pick
    import vic_pkg::*;
(
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] hi_sel,
    input  logic             isr_hi,
    input  logic             isr_lo,
    output pick_t            pick
);
    logic [SRC_N-1:0] hi_set;
    logic [SRC_N-1:0] lo_set;

    assign hi_set = pend & hi_sel;
    assign lo_set = pend & ~hi_sel;

    // Level rule first, then the fixed order within the chosen level.
    always_comb begin
        pick = '0;
        if (isr_hi) begin
            pick = '0;
        end else if (|hi_set) begin
            pick.valid = 1'b1;
            pick.hi    = 1'b1;
            pick.idx   = lowest_idx(hi_set);
        end else if (!isr_lo && (|lo_set)) begin
            pick.valid = 1'b1;
            pick.hi    = 1'b0;
            pick.idx   = lowest_idx(lo_set);
        end
    end
endmodule

// File: rtl/vic_levels.sv
// In-service tracker: one bit per level. A take sets its level's bit; a return
// clears the high bit if it is set, otherwise the low bit. If both arrive
// together, the return is applied first and then the take.
module vic_levels (
    input  logic clk,
    input  logic rst_n,
    input  logic take_en,
    input  logic take_hi,
    input  logic ret,
    output logic isr_hi,
    output logic isr_lo
);
    logic hi_n;
    logic lo_n;

    // Next-state: unwind one level on return, then mark the new level.
    always_comb begin
        hi_n = isr_hi;
        lo_n = isr_lo;
        if (ret) begin
            if (hi_n) hi_n = 1'b0;
            else      lo_n = 1'b0;
        end
        if (take_en) begin
            if (take_hi) hi_n = 1'b1;
            else         lo_n = 1'b1;
        end
    end

    // Level state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_hi <= 1'b0;
            isr_lo <= 1'b0;
        end else begin
            isr_hi <= hi_n;
            isr_lo <= lo_n;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top: enable and level registers, request flags, the arbiter, the level
// tracker and the registered take/vector outputs. Assumes insn_done and reti
// are one-cycle strobes from the core. Source order: ext0, tmr0, ext1, tmr1, serial.
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter int               VEC_BASE = 3,
    parameter int               VEC_STEP = 8,
    parameter logic [SRC_N-1:0] TMR_MASK = 5'b01010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [SRC_N:0]    en_wdata,
    input  logic              pri_we,
    input  logic [SRC_N-1:0]  pri_wdata,
    input  logic              ext0_req,
    input  logic              ext1_req,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              ser_tx_flag,
    input  logic              ser_rx_flag,
    input  logic              insn_done,
    input  logic              reti,
    output logic              take,
    output logic [ADDR_W-1:0] vec_addr
);
    logic [SRC_N:0]   en_q;
    logic [SRC_N-1:0] pri_q;
    logic [SRC_N-1:0] evt;
    logic [SRC_N-1:0] flag;
    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] clr;
    logic             glb_en;
    logic             fire;
    logic             isr_hi;
    logic             isr_lo;
    pick_t            pick;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (pri_we) pri_q <= pri_wdata;
        end
    end

    assign evt    = {ser_tx_flag | ser_rx_flag, tmr1_ovf, ext1_req, tmr0_ovf, ext0_req};
    assign glb_en = en_q[SRC_N];
    assign pend   = flag & en_q[SRC_N-1:0] & {SRC_N{glb_en}};
    assign fire   = insn_done & pick.valid;
    assign clr    = fire ? (SRC_N'(1) << pick.idx) : '0;

    vic_flags #(
        .N          (SRC_N),
        .LATCH_MASK (TMR_MASK)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr),
        .flag  (flag)
    );

    vic_pick u_pick (
        .pend   (pend),
        .hi_sel (pri_q),
        .isr_hi (isr_hi),
        .isr_lo (isr_lo),
        .pick   (pick)
    );

    vic_levels u_levels (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_en (fire),
        .take_hi (pick.hi),
        .ret     (reti),
        .isr_hi  (isr_hi),
        .isr_lo  (isr_lo)
    );

    // Registered take pulse and entry address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take     <= 1'b0;
            vec_addr <= '0;
        end else begin
            take <= fire;
            if (fire) vec_addr <= ADDR_W'(VEC_BASE + int'(pick.idx) * VEC_STEP);
        end
    end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
// Checker for vec_irq_ctrl: properties on take timing, masking, level nesting
// and the entry address grid. It is attached to every instance by the bind below.
module vec_irq_ctrl_chk #(
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8,
    parameter int SRC_N    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              glb_en,
    input logic              isr_hi,
    input logic              isr_lo,
    input logic              insn_done
);
    localparam int VEC_LAST = VEC_BASE + (SRC_N - 1) * VEC_STEP;

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(insn_done)); // R5
    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !take); // R3
    AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        isr_hi |=> !take); // R9
    AST_LOW_ONLY_BY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_lo && !isr_hi) |=> (!take || isr_hi)); // R8
    AST_VECTOR_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (((int'(vec_addr) - VEC_BASE) % VEC_STEP) == 0
                  && int'(vec_addr) <= VEC_LAST)); // R2
    AST_LEVEL_SET_BY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(isr_hi) || $rose(isr_lo)) |-> take); // R10
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP),
    .SRC_N    (vic_pkg::SRC_N)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .vec_addr  (vec_addr),
    .glb_en    (glb_en),
    .isr_hi    (isr_hi),
    .isr_lo    (isr_lo),
    .insn_done (insn_done)
);

// File: tb/vec_irq_ctrl_tb.sv
// Scoreboard bench: driver tasks queue the expected outcome of each boundary
// strobe, and a monitor compares take/vec_addr one cycle later.
module vec_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_we = 1'b0, pri_we = 1'b0;
    logic [5:0]  en_wdata = '0;
    logic [4:0]  pri_wdata = '0;
    logic        ext0_req = 0, ext1_req = 0, tmr0_ovf = 0, tmr1_ovf = 0;
    logic        ser_tx_flag = 0, ser_rx_flag = 0, insn_done = 0, reti = 0;
    logic        take;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic strobed_d = 1'b0;

    typedef struct {
        logic        exp;
        logic [15:0] vec;
        string       tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
        .pri_we(pri_we), .pri_wdata(pri_wdata), .ext0_req(ext0_req),
        .ext1_req(ext1_req), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ser_tx_flag(ser_tx_flag), .ser_rx_flag(ser_rx_flag),
        .insn_done(insn_done), .reti(reti), .take(take), .vec_addr(vec_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: remember boundary strobes, compare one cycle after each one.
    always @(posedge clk) strobed_d <= insn_done;
    always @(negedge clk) begin
        if (rst_n && strobed_d) begin
            if (q.size() == 0) begin
                chk(1'b0, "scoreboard empty", {15'd0, take}, 16'd0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(take === it.exp && (!it.exp || vec_addr === it.vec),
                    it.tag, take ? vec_addr : 16'hFFFF, it.exp ? it.vec : 16'hFFFF);
            end
        end else if (rst_n && take) begin
            chk(1'b0, "R5 take without boundary", vec_addr, 16'hFFFF);
        end
    end

    task automatic strobe(input logic exp, input logic [15:0] vec, input string tag);
        item_t it;
        it.exp = exp; it.vec = vec; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #2 insn_done = 1'b1;
        @(posedge clk); #2 insn_done = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic do_reti();
        @(posedge clk); #2 reti = 1'b1;
        @(posedge clk); #2 reti = 1'b0;
    endtask

    task automatic wr_en(input logic [5:0] v);
        @(posedge clk); #2 en_we = 1'b1; en_wdata = v;
        @(posedge clk); #2 en_we = 1'b0;
    endtask

    task automatic wr_pri(input logic [4:0] v);
        @(posedge clk); #2 pri_we = 1'b1; pri_wdata = v;
        @(posedge clk); #2 pri_we = 1'b0;
    endtask

    task automatic pulse_tmr(input int which);
        @(posedge clk); #2 if (which == 0) tmr0_ovf = 1'b1; else tmr1_ovf = 1'b1;
        @(posedge clk); #2 tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(take === 1'b0 && vec_addr === 16'h0, "R1 reset outputs", vec_addr, 16'h0);
        #2 rst_n = 1'b1;

        // R1: registers reset, so a request is not taken.
        ext0_req = 1'b1;
        strobe(1'b0, 16'h0, "R1 no take after reset");
        // R3: all individual enables on, global off.
        wr_en(6'b011111);
        strobe(1'b0, 16'h0, "R3 global enable off");
        // R4: global on, ext0 disabled.
        wr_en(6'b111110);
        strobe(1'b0, 16'h0, "R4 source disabled");
        ext0_req = 1'b0;
        wr_en(6'b111111);

        // R2: each source alone, all at the low level.
        ext0_req = 1'b1; strobe(1'b1, 16'h0003, "R2 ext0 vector"); ext0_req = 1'b0; do_reti();
        pulse_tmr(0);    strobe(1'b1, 16'h000B, "R2 tmr0 vector"); do_reti();
        ext1_req = 1'b1; strobe(1'b1, 16'h0013, "R2 ext1 vector"); ext1_req = 1'b0; do_reti();
        pulse_tmr(1);    strobe(1'b1, 16'h001B, "R2 tmr1 vector"); do_reti();
        ser_tx_flag = 1'b1; strobe(1'b1, 16'h0023, "R2 serial vector"); ser_tx_flag = 1'b0; do_reti();

        // R7: same level, lower index wins; R8: low does not nest on low.
        ext1_req = 1'b1; ser_tx_flag = 1'b1;
        strobe(1'b1, 16'h0013, "R7 ext1 before serial");
        strobe(1'b0, 16'h0, "R8 low blocked by low");
        do_reti();
        strobe(1'b1, 16'h0013, "R7 ext1 again after return");
        ext1_req = 1'b0; do_reti();
        strobe(1'b1, 16'h0023, "R7 serial next");
        ser_tx_flag = 1'b0; do_reti();

        // R6/R9/R8/R10: serial at the high level.
        wr_pri(5'b10000);
        ext0_req = 1'b1; ser_tx_flag = 1'b1;
        strobe(1'b1, 16'h0023, "R6 high beats polling order");
        strobe(1'b0, 16'h0, "R9 high in service blocks");
        ser_tx_flag = 1'b0; do_reti();
        strobe(1'b1, 16'h0003, "R10 low taken after high ends");
        ser_tx_flag = 1'b1;
        strobe(1'b1, 16'h0023, "R8 high preempts low");
        ser_tx_flag = 1'b0; do_reti();
        strobe(1'b0, 16'h0, "R10 low still in service");
        do_reti();
        strobe(1'b1, 16'h0003, "R10 low free after second return");
        ext0_req = 1'b0; do_reti();
        wr_pri(5'b00000);

        // R11: timer flag cleared by take; serial flag is not.
        pulse_tmr(1);
        strobe(1'b1, 16'h001B, "R11 tmr1 taken");
        do_reti();
        strobe(1'b0, 16'h0, "R11 tmr1 flag cleared");
        ser_rx_flag = 1'b1;
        strobe(1'b1, 16'h0023, "R11 serial via rx");
        do_reti();
        strobe(1'b1, 16'h0023, "R11 serial not cleared");
        ser_rx_flag = 1'b0; do_reti();

        // R5: a pending request waits for a boundary.
        ext0_req = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(take === 1'b0, "R5 no take between boundaries", {15'd0, take}, 16'h0);
        strobe(1'b1, 16'h0003, "R5 taken at boundary");
        ext0_req = 1'b0; do_reti();

        repeat (3) @(posedge clk);
        chk(q.size() == 0, "scoreboard drained", 16'(q.size()), 16'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule